// File: doc/BRIEF.md
# Tile Plane Scanline Renderer

This block draws one horizontal line of a scrolling tile plane into a pair of alternating line buffers. While the display side reads the line that has just been finished, the block prepares the next one. Each line starts with a horizontal-blank strobe from the video timing logic. At that strobe the block latches the line number and the plane settings, and flips the two buffers. It then paints the backdrop colour over the buffer it is about to draw.

Next it reads the tilemap entries that cover the line from video memory, one per clock. After that it reads the 4-bit pattern words of those tiles and writes one palette index per clock into the buffer. Writing a single pixel per clock keeps each buffer a plain one-write, one-read memory.

Video memory is a synchronous single-port read memory with a one-cycle latency. Tiles are 8x8 pixels. The tilemap is 64 columns by 64 rows, and both scroll axes wrap at 512 pixels.

Top module: `tile_line_renderer`

## Requirements
- R1: While idle the block issues no memory read and leaves the buffers unchanged. A cycle with `hstrobe` high in idle latches `line_num`, `map_base`, `pat_base`, `scroll_x` and `scroll_y`, then exchanges the drawing and display buffers. After that strobe, changing those inputs does not alter the line being drawn.
- R2: A strobe that arrives while a line is still being rendered is ignored. It does not swap the buffers and does not restart the line.
- R3: Before any tile pixel is written, each of the 320 entries of the drawing buffer is set to 0, which is the backdrop value. Entries that no opaque pixel covers read back as 0.
- R4: Each line reads exactly 41 tilemap entries, one per clock. The first read address is `map_base + 64*row + coarse`, where `row` = ((line+scroll_y) mod 512)/8 and `coarse` = `scroll_x[8:3]`. Each later entry takes the next column, modulo 64. Each line makes 123 memory reads in total.
- R5: `vram_rdata` is consumed exactly one cycle after the read that requested it. `vram_rd` is low in reset and in idle.
- R6: A tilemap entry carries the tile number in bits 9:0 and the palette row in bits 15:12. Pattern word h (0 = left half, 1 = right half) of pattern row r is read at `pat_base + 16*tile + 2*r + h`.
- R7: Within a pattern word, bits 15:12 are the leftmost pixel and bits 3:0 the rightmost. A buffer entry holds the palette row in bits 7:4 and the pixel in bits 3:0. A pixel value of 0 is transparent and is not written.
- R8: Screen pixel x shows plane pixel x + `scroll_x`, so the first `scroll_x[2:0]` pixels of the first tile are dropped. Pixels that land outside columns 0 to 319 are discarded.
- R9: The pattern row is (line + `scroll_y`) mod 8. The tile row wraps at 64, and tile columns wrap at 64.
- R10: The drawing buffer receives at most one write per clock, always to an address from 0 to 319. After the 82nd pattern word the block returns to idle and issues no further reads.
- R11: The display port returns entry `disp_x` of the display buffer one clock after `disp_x` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hstrobe | input | 1 | Horizontal-blank start pulse |
| line_num | input | 8 | Scanline to render, 0 to 239 |
| map_base | input | 15 | Tilemap word address |
| pat_base | input | 15 | Pattern table word address |
| scroll_x | input | 9 | Horizontal scroll in pixels |
| scroll_y | input | 9 | Vertical scroll in pixels |
| vram_rd | output | 1 | Memory read request |
| vram_addr | output | 15 | Memory read word address |
| vram_rdata | input | 16 | Read data, valid one cycle after the request |
| disp_x | input | 9 | Display-side pixel column |
| disp_pix | output | 8 | Palette index of that column, one cycle later |

## Verification
The bench renders lines with fine scroll values other than zero. A renderer that ignored the fine offset would shift every pixel, and one that did not clip would spill into column 0. It also uses scroll values that wrap both the tile column and the tile row, which catches a missing modulo that would fetch entries from the wrong row or column.

A second strobe is sent partway through a line, together with changed settings. A design that accepted that strobe, or that did not latch its settings, would show the wrong buffer or a mixed line. Buffers are reused across lines, so a missing backdrop fill shows up as stale pixels where the pattern is transparent. The read count and the first map address confirm the fetch length and where the fetch starts.

// File: rtl/tlr_pkg.sv
package tlr_pkg;

    localparam int LINE_PIX_DEF    = 320;
    localparam int FETCH_TILES_DEF = 41;
    localparam int VRAM_AW_DEF     = 15;
    localparam int MAP_COL_W       = 6;
    localparam int MAP_ROW_W       = 6;
    localparam int SCRL_W_DEF      = MAP_COL_W + 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CLEAR = 3'd1,
        ST_MAP   = 3'd2,
        ST_PRIME = 3'd3,
        ST_LOAD  = 3'd4,
        ST_PIX   = 3'd5
    } rstate_e;

    typedef struct packed {
        logic [3:0] pal_row;
        logic [1:0] spare;
        logic [9:0] tile_idx;
    } map_entry_t;

    // slot 0 is the leftmost pixel, held in the top nibble
    function automatic logic [3:0] word_nibble(input logic [15:0] w, input logic [1:0] slot);
        logic [3:0] n;
        case (slot)
            2'd0:    n = w[15:12];
            2'd1:    n = w[11:8];
            2'd2:    n = w[7:4];
            default: n = w[3:0];
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tlr_line_ram.sv
module tlr_line_ram #(
    parameter int DEPTH = 320,
    parameter int AW    = 9,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/tlr_pix_unpack.sv
module tlr_pix_unpack import tlr_pkg::*; #(
    parameter int LINE_PIX = LINE_PIX_DEF,
    parameter int XW       = 9
) (
    input  logic          pix_active,
    input  logic [15:0]   hold_word,
    input  logic [1:0]    slot,
    input  logic [3:0]    pal_row,
    input  logic [XW:0]   word_x,
    output logic          px_we,
    output logic [XW-1:0] px_addr,
    output logic [7:0]    px_data
);
    logic [3:0] nib;
    logic [XW:0] xs;
    logic in_range;

    always_comb begin
        nib      = word_nibble(hold_word, slot);
        // negative positions show up with the top bit set
        xs       = word_x + (XW+1)'(slot);
        in_range = !xs[XW] && (xs[XW-1:0] < XW'(LINE_PIX));
        px_we    = pix_active && (nib != 4'd0) && in_range;
        px_addr  = xs[XW-1:0];
        px_data  = {pal_row, nib};
    end
endmodule

// File: rtl/tlr_seq.sv
module tlr_seq import tlr_pkg::*; #(
    parameter int VRAM_AW  = VRAM_AW_DEF,
    parameter int LINE_PIX = LINE_PIX_DEF,
    parameter int TILES    = FETCH_TILES_DEF,
    parameter int LINE_W   = 8,
    parameter int XW       = 9,
    parameter int SCRL_W   = SCRL_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hstrobe,
    input  logic [LINE_W-1:0]  line_num,
    input  logic [VRAM_AW-1:0] map_base,
    input  logic [VRAM_AW-1:0] pat_base,
    input  logic [SCRL_W-1:0]  scroll_x,
    input  logic [SCRL_W-1:0]  scroll_y,
    output logic               vram_rd,
    output logic [VRAM_AW-1:0] vram_addr,
    input  logic [15:0]        vram_rdata,
    output rstate_e            st,
    output logic               draw_sel,
    output logic               clr_we,
    output logic [XW-1:0]      clr_addr,
    output logic               pix_active,
    output logic [15:0]        hold_word,
    output logic [1:0]         slot,
    output logic [3:0]         pal_row,
    output logic [XW:0]        word_x
);
    localparam int WORDS = TILES * 2;
    localparam int CW    = $clog2(WORDS + 1);
    localparam int TW    = $clog2(TILES);
    localparam logic [CW-1:0] LAST_WORD = CW'(WORDS - 1);

    rstate_e            st_q;
    logic [CW-1:0]      cnt_q;
    logic [1:0]         slot_q;
    logic [XW-1:0]      clr_q;
    logic [15:0]        hold_q;
    logic [15:0]        tiles_q [TILES];
    logic [VRAM_AW-1:0] mbase_q, pbase_q;
    logic [SCRL_W-1:0]  sx_q, sy_q;
    logic [LINE_W-1:0]  line_q;
    logic               sel_q;

    logic [SCRL_W-1:0]    ysum;
    logic [MAP_ROW_W-1:0] trow;
    logic [2:0]           prow;
    logic [MAP_COL_W-1:0] map_col;
    logic [VRAM_AW-1:0]   map_addr;
    logic [CW-1:0]        nxt_word;
    map_entry_t           nxt_ent, cur_ent;
    logic [VRAM_AW-1:0]   pat_addr;

    always_comb begin
        ysum     = SCRL_W'(line_q) + sy_q;
        trow     = ysum[SCRL_W-1:3];
        prow     = ysum[2:0];
        map_col  = sx_q[SCRL_W-1:3] + cnt_q[MAP_COL_W-1:0];
        map_addr = mbase_q + VRAM_AW'({trow, map_col});
        nxt_word = (st_q == ST_PRIME) ? '0 : cnt_q + CW'(1);
        nxt_ent  = map_entry_t'(tiles_q[TW'(nxt_word >> 1)]);
        cur_ent  = map_entry_t'(tiles_q[TW'(cnt_q >> 1)]);
        pat_addr = pbase_q + VRAM_AW'({nxt_ent.tile_idx, prow, nxt_word[0]});
    end

    always_comb begin
        vram_rd   = 1'b0;
        vram_addr = '0;
        unique case (st_q)
            ST_MAP: begin
                if (cnt_q < CW'(TILES)) begin
                    vram_rd   = 1'b1;
                    vram_addr = map_addr;
                end
            end
            ST_PRIME: begin
                vram_rd   = 1'b1;
                vram_addr = pat_addr;
            end
            ST_PIX: begin
                // request the next word so it lands as the last pixel goes out
                if (slot_q == 2'd2 && cnt_q != LAST_WORD) begin
                    vram_rd   = 1'b1;
                    vram_addr = pat_addr;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            sel_q  <= 1'b0;
            cnt_q  <= '0;
            slot_q <= '0;
            clr_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (hstrobe) begin
                        line_q  <= line_num;
                        mbase_q <= map_base;
                        pbase_q <= pat_base;
                        sx_q    <= scroll_x;
                        sy_q    <= scroll_y;
                        sel_q   <= ~sel_q;
                        clr_q   <= '0;
                        st_q    <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    if (clr_q == XW'(LINE_PIX - 1)) begin
                        cnt_q <= '0;
                        st_q  <= ST_MAP;
                    end else begin
                        clr_q <= clr_q + XW'(1);
                    end
                end
                ST_MAP: begin
                    if (cnt_q != '0) tiles_q[TW'(cnt_q - CW'(1))] <= vram_rdata;
                    if (cnt_q == CW'(TILES)) begin
                        cnt_q <= '0;
                        st_q  <= ST_PRIME;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
                ST_PRIME: st_q <= ST_LOAD;
                ST_LOAD: begin
                    hold_q <= vram_rdata;
                    slot_q <= '0;
                    st_q   <= ST_PIX;
                end
                ST_PIX: begin
                    slot_q <= slot_q + 2'd1;
                    if (slot_q == 2'd3) begin
                        if (cnt_q == LAST_WORD) begin
                            st_q <= ST_IDLE;
                        end else begin
                            hold_q <= vram_rdata;
                            cnt_q  <= cnt_q + CW'(1);
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign st         = st_q;
    assign draw_sel   = sel_q;
    assign clr_we     = (st_q == ST_CLEAR);
    assign clr_addr   = clr_q;
    assign pix_active = (st_q == ST_PIX);
    assign hold_word  = hold_q;
    assign slot       = slot_q;
    assign pal_row    = cur_ent.pal_row;
    assign word_x     = (XW+1)'({cnt_q, 2'b00}) - (XW+1)'(sx_q[2:0]);
endmodule

// File: rtl/tile_line_renderer.sv
module tile_line_renderer import tlr_pkg::*; #(
    parameter int VRAM_AW     = VRAM_AW_DEF,
    parameter int LINE_PIX    = LINE_PIX_DEF,
    parameter int FETCH_TILES = FETCH_TILES_DEF,
    parameter int LINE_W      = 8,
    parameter int SCRL_W      = SCRL_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hstrobe,
    input  logic [LINE_W-1:0]  line_num,
    input  logic [VRAM_AW-1:0] map_base,
    input  logic [VRAM_AW-1:0] pat_base,
    input  logic [SCRL_W-1:0]  scroll_x,
    input  logic [SCRL_W-1:0]  scroll_y,
    output logic               vram_rd,
    output logic [VRAM_AW-1:0] vram_addr,
    input  logic [15:0]        vram_rdata,
    input  logic [$clog2(LINE_PIX)-1:0] disp_x,
    output logic [7:0]         disp_pix
);
    localparam int XW = $clog2(LINE_PIX);

    rstate_e       st_w;
    logic          draw_sel_w;
    logic          clr_we;
    logic [XW-1:0] clr_addr;
    logic          pix_active;
    logic [15:0]   hold_word;
    logic [1:0]    slot;
    logic [3:0]    pal_row;
    logic [XW:0]   word_x;
    logic          px_we;
    logic [XW-1:0] px_addr;
    logic [7:0]    px_data;
    logic          lb_we;
    logic [XW-1:0] lb_waddr;
    logic [7:0]    lb_wdata;
    logic [7:0]    bank_rd [2];
    logic          disp_bank_q;

    tlr_seq #(
        .VRAM_AW(VRAM_AW), .LINE_PIX(LINE_PIX), .TILES(FETCH_TILES),
        .LINE_W(LINE_W), .XW(XW), .SCRL_W(SCRL_W)
    ) u_seq (
        .clk(clk), .rst(rst), .hstrobe(hstrobe), .line_num(line_num),
        .map_base(map_base), .pat_base(pat_base),
        .scroll_x(scroll_x), .scroll_y(scroll_y),
        .vram_rd(vram_rd), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .st(st_w), .draw_sel(draw_sel_w),
        .clr_we(clr_we), .clr_addr(clr_addr),
        .pix_active(pix_active), .hold_word(hold_word), .slot(slot),
        .pal_row(pal_row), .word_x(word_x)
    );

    tlr_pix_unpack #(.LINE_PIX(LINE_PIX), .XW(XW)) u_unpack (
        .pix_active(pix_active), .hold_word(hold_word), .slot(slot),
        .pal_row(pal_row), .word_x(word_x),
        .px_we(px_we), .px_addr(px_addr), .px_data(px_data)
    );

    // backdrop fill and pixel writes never overlap in time
    assign lb_we    = clr_we | px_we;
    assign lb_waddr = clr_we ? clr_addr : px_addr;
    assign lb_wdata = clr_we ? 8'h00 : px_data;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        tlr_line_ram #(.DEPTH(LINE_PIX), .AW(XW), .DW(8)) u_ram (
            .clk(clk),
            .we(lb_we && (draw_sel_w == 1'(b))),
            .waddr(lb_waddr),
            .wdata(lb_wdata),
            .raddr(disp_x),
            .rdata(bank_rd[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) disp_bank_q <= 1'b1;
        else     disp_bank_q <= ~draw_sel_w;
    end

    assign disp_pix = bank_rd[disp_bank_q];
endmodule

// File: rtl/tlr_checker.sv
module tlr_checker import tlr_pkg::*; #(
    parameter int TILES    = FETCH_TILES_DEF,
    parameter int LINE_PIX = LINE_PIX_DEF,
    parameter int XW       = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          hstrobe,
    input rstate_e       st,
    input logic          vram_rd,
    input logic          draw_sel,
    input logic          lb_we,
    input logic [XW-1:0] lb_waddr,
    input logic [7:0]    lb_wdata
);
    logic [7:0] map_cnt;

    always_ff @(posedge clk) begin
        if (rst || st == ST_CLEAR) map_cnt <= '0;
        else if (st == ST_MAP && vram_rd) map_cnt <= map_cnt + 8'd1;
    end

    p_idle_no_read_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !vram_rd);

    p_strobe_swaps_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && hstrobe) |=> (draw_sel != $past(draw_sel)));

    p_stay_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !hstrobe) |=> (st == ST_IDLE));

    p_busy_no_swap_r2: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(draw_sel));

    p_map_fetch_count_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PRIME) |-> (map_cnt == 8'(TILES)));

    p_write_in_range_r10: assert property (@(posedge clk) disable iff (rst)
        lb_we |-> (lb_waddr < XW'(LINE_PIX)));

    p_opaque_only_r7: assert property (@(posedge clk) disable iff (rst)
        (lb_we && st == ST_PIX) |-> (lb_wdata[3:0] != 4'd0));
endmodule

bind tile_line_renderer tlr_checker u_chk (
    .clk(clk), .rst(rst), .hstrobe(hstrobe), .st(st_w), .vram_rd(vram_rd),
    .draw_sel(draw_sel_w), .lb_we(lb_we), .lb_waddr(lb_waddr), .lb_wdata(lb_wdata)
);

// File: tb/tile_line_renderer_tb_top.sv
module tile_line_renderer_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hstrobe = 1'b0;
    logic [7:0]  line_num = '0;
    logic [14:0] map_base = '0;
    logic [14:0] pat_base = '0;
    logic [8:0]  scroll_x = '0;
    logic [8:0]  scroll_y = '0;
    logic        vram_rd;
    logic [14:0] vram_addr;
    logic [15:0] vram_rdata = '0;
    logic [8:0]  disp_x = '0;
    logic [7:0]  disp_pix;

    int n_vec = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int first_addr = -1;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       mon_en = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    tile_line_renderer dut_i (
        .clk(clk), .rst(rst), .hstrobe(hstrobe), .line_num(line_num),
        .map_base(map_base), .pat_base(pat_base),
        .scroll_x(scroll_x), .scroll_y(scroll_y),
        .vram_rd(vram_rd), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .disp_x(disp_x), .disp_pix(disp_pix)
    );

    function automatic logic [15:0] vram_word(input int a);
        int v;
        v = a * 40503 + 12345;
        v = v ^ (v >>> 7);
        return v[15:0];
    endfunction

    // memory image is a function of the address; one-cycle read latency
    always @(posedge clk) if (vram_rd) vram_rdata <= vram_word(int'(vram_addr));

    always @(negedge clk) begin
        if (!rst && vram_rd) begin
            if (rd_cnt == 0) first_addr = int'(vram_addr);
            rd_cnt++;
        end
    end

    function automatic logic [7:0] ref_pix(input int ln, input int x, input int mb,
                                           input int pb, input int sx, input int sy);
        int y, trow, prow, mx, col, px, ent, idx, pal, pw, nib;
        y    = (ln + sy) & 511;
        trow = y >> 3;
        prow = y & 7;
        mx   = x + sx;
        col  = (mx >> 3) & 63;
        px   = mx & 7;
        ent  = int'(vram_word((mb + trow * 64 + col) & 32767));
        idx  = ent & 1023;
        pal  = (ent >> 12) & 15;
        pw   = int'(vram_word((pb + idx * 16 + prow * 2 + (px >> 2)) & 32767));
        nib  = (pw >> (12 - 4 * (px & 3))) & 15;
        return (nib == 0) ? 8'h00 : 8'(pal * 16 + nib);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // monitor: one comparison per clock while the driver has items queued
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_en && exp_q.size() > 0)
                check(tag_q.pop_front(), int'(disp_pix), int'(exp_q.pop_front()));
        end
    end

    task automatic set_cfg(input int ln, input int mb, input int pb, input int sx, input int sy);
        line_num = 8'(ln);
        map_base = 15'(mb);
        pat_base = 15'(pb);
        scroll_x = 9'(sx);
        scroll_y = 9'(sy);
    endtask

    task automatic pulse_strobe();
        @(negedge clk) hstrobe = 1'b1;
        @(negedge clk) hstrobe = 1'b0;
    endtask

    // driver: reads the shown buffer, pushing the expected entry for each column
    task automatic show_line(input string tag, input int ln, input int mb,
                             input int pb, input int sx, input int sy);
        for (int x = 0; x < 320; x++) begin
            logic [7:0] e;
            @(negedge clk);
            disp_x = 9'(x);
            e = ref_pix(ln, x, mb, pb, sx, sy);
            exp_q.push_back(e);
            tag_q.push_back((e == 8'h00) ? "R3" : tag);
            mon_en = 1'b1;
        end
        @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic render_and_check(input string tag, input int ln, input int mb,
                                    input int pb, input int sx, input int sy);
        int hold_cnt;
        set_cfg(ln, mb, pb, sx, sy);
        rd_cnt = 0;
        pulse_strobe();
        repeat (800) @(negedge clk);
        check("R4 read count", rd_cnt, 123);
        check("R4 first map address", first_addr,
              (mb + (((ln + sy) & 511) >> 3) * 64 + ((sx >> 3) & 63)) & 32767);
        hold_cnt = rd_cnt;
        repeat (20) @(negedge clk);
        check("R10 idle after line", rd_cnt, hold_cnt);
        pulse_strobe();          // swap: the finished line becomes visible
        show_line(tag, ln, mb, pb, sx, sy);
        repeat (500) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R5 reset no read", int'(vram_rd), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        check("R1 idle no read", rd_cnt, 0);

        // R11 display latency and R7 nibble order / palette row packing
        render_and_check("R11", 0, 'h0000, 'h4000, 0, 0);
        render_and_check("R7", 17, 'h0800, 'h1000, 0, 2);
        // R8 coarse and fine horizontal scroll; R6 pattern addressing throughout
        render_and_check("R8", 100, 'h1000, 'h2000, 'h1D, 13);
        render_and_check("R6", 201, 'h3000, 'h5100, 'h0F, 0);
        // R9 wrap of column, row, and address space
        render_and_check("R9", 239, 'h7F00, 'h7000, 509, 500);

        // R2 strobe during rendering is ignored; R1 settings latched at the strobe
        set_cfg(50, 'h2200, 'h0400, 6, 3);
        rd_cnt = 0;
        pulse_strobe();
        repeat (100) @(negedge clk);
        set_cfg(7, 'h0100, 'h6000, 200, 77);
        pulse_strobe();
        repeat (800) @(negedge clk);
        check("R2 read count", rd_cnt, 123);
        pulse_strobe();
        show_line("R2", 50, 'h2200, 'h0400, 6, 3);
        repeat (500) @(negedge clk);

        finish_run();
    end
endmodule